// File: doc/BRIEF.md
# Parking Gate Controller

This block drives a car-park barrier and tracks how many cars are inside. When a validated card is presented, the barrier is raised for a fixed number of clock cycles and then lowered. At the moment the barrier drops, a one-cycle expiry pulse is issued. Admissions count the occupancy up and exit-sensor events count it down. The count is bounded by a capacity limit, and a full flag is raised when the limit is reached. While the flag is high, further cards are refused.

Both the card and exit inputs pass through rising-edge detection, so a level held for many cycles counts as a single event. Every state element, including the barrier output, the hold counter and the occupancy, is a flip-flop updated on the rising clock edge. The reset is synchronous and active high. With the default parameters the hold time is 500,000,000 cycles, which is ten seconds at 50 MHz, and the capacity is 99.

Top module: `parking_gate_ctrl`

## Requirements
- R1: While reset is high at a clock edge, the following edge leaves the barrier closed, the expiry pulse low, the occupancy at 0 and the full flag low. Card and exit inputs have no effect during reset.
- R2: A rising edge on the card input while the lot is not full is an admission. From the next cycle the barrier is open and the occupancy is one higher.
- R3: A card or exit input held high for several cycles counts as exactly one event.
- R4: After the last admission, the barrier stays open for exactly HOLD_CYCLES cycles, counting the cycle in which it opens. In the first cycle after that it is closed, and the expiry pulse is high for that one cycle only.
- R5: An admission while the barrier is already open restarts the full hold time and increments the occupancy.
- R6: A rising edge on the exit input decrements the occupancy. At occupancy 0 the exit event is ignored and the count stays 0.
- R7: When an admission and an exit event fall in the same cycle, the occupancy is unchanged and the barrier opens.
- R8: At occupancy CAPACITY a card event is refused: the barrier does not open and the count does not change. An exit event arriving in the same cycle still decrements the count.
- R9: The full flag is high exactly when the occupancy equals CAPACITY.
- R10: The occupancy never exceeds CAPACITY and changes by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| card_ok_i | input | 1 | Card-validated level; its rising edge requests entry |
| exit_seen_i | input | 1 | Exit sensor level; its rising edge signals a departure |
| barrier_open_o | output | 1 | High while the barrier is raised |
| hold_done_o | output | 1 | One-cycle pulse when the hold time ends |
| occupancy_o | output | CNT_W | Cars currently inside, CNT_W = clog2(CAPACITY+1) |
| lot_full_o | output | 1 | High when occupancy equals CAPACITY |

## Verification
The bench uses a small configuration with a hold of 8 cycles and a capacity of 5. It counts every cycle of the barrier window, so a design that is off by one in the hold counter, or that lets a held card retrigger the timer, shows the barrier dropping one cycle early or late. A restart part-way through a window catches a design that ignores a second card and would close too soon. The bench fills the lot to capacity and drains it back to zero one car at a time. At each step it checks the full flag. It also probes the edges of the count: a card at capacity, which must not open the barrier or wrap the count; an exit at zero, which must not underflow to the maximum code; and simultaneous card and exit events at capacity and below it. A reset during an open window must close the barrier at once.

// File: rtl/pgate_pkg.sv
package pgate_pkg;

  // Edge-detected request lines entering the controller
  typedef struct packed {
    logic enter;
    logic leave;
  } pgate_evt_t;

  localparam int unsigned EVT_W = $bits(pgate_evt_t);

endpackage

// File: rtl/pgate_edge.sv
module pgate_edge #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);

  logic [W-1:0] lvl_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) lvl_q[g] <= 1'b0;
      else     lvl_q[g] <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] & ~lvl_q[g];

    // R3
    single_event_chk: assert property (@(posedge clk) disable iff (rst)
      rise_o[g] |=> !rise_o[g]);
  end

endmodule

// File: rtl/pgate_occupancy.sv
module pgate_occupancy #(
  parameter int unsigned CAPACITY = 99,
  localparam int unsigned CNT_W   = $clog2(CAPACITY + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enter_req,
  input  logic             leave_req,
  output logic             admit_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o
);

  localparam logic [CNT_W-1:0] CAP_C = CNT_W'(CAPACITY);

  logic [CNT_W-1:0] count_q, count_d;
  logic             full_q;
  logic             dec_ok;

  // Entry refused at capacity; an exit at zero only counts if an admission
  // in the same cycle offsets it.
  assign admit_o = enter_req & ~full_q;
  assign dec_ok  = leave_req & ((count_q != '0) | admit_o);

  always_comb begin
    count_d = count_q + CNT_W'(admit_o) - CNT_W'(dec_ok);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      full_q  <= 1'b0;
    end else begin
      count_q <= count_d;
      full_q  <= (count_d == CAP_C);
    end
  end

  assign count_o = count_q;
  assign full_o  = full_q;

  // R2
  enter_count_chk: assert property (@(posedge clk) disable iff (rst)
    (admit_o && !leave_req) |=> (count_o == $past(count_o) + 1'b1));
  // R6
  floor_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (count_o == '0 && !enter_req) |=> (count_o == '0));
  // R8
  full_block_chk: assert property (@(posedge clk) disable iff (rst)
    (full_o && !leave_req) |=> (count_o == $past(count_o)));
  // R9
  full_flag_chk: assert property (@(posedge clk) disable iff (rst)
    full_o == (count_o == CAP_C));
  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    count_o <= CAP_C);

endmodule

// File: rtl/pgate_hold_timer.sv
module pgate_hold_timer #(
  parameter int unsigned HOLD_CYCLES = 500_000_000,
  localparam int unsigned TW         = $clog2(HOLD_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic open_o,
  output logic expire_o
);

  localparam logic [TW-1:0] TERM_C = TW'(HOLD_CYCLES);

  logic [TW-1:0] cnt_q;
  logic          open_q, exp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      open_q <= 1'b0;
      exp_q  <= 1'b0;
    end else begin
      exp_q <= 1'b0;
      if (start_i) begin
        open_q <= 1'b1;
        cnt_q  <= TW'(1);
      end else if (open_q) begin
        if (cnt_q == TERM_C) begin
          open_q <= 1'b0;
          cnt_q  <= '0;
          exp_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign open_o   = open_q;
  assign expire_o = exp_q;

  // R4
  expire_closed_chk: assert property (@(posedge clk) disable iff (rst)
    expire_o |-> !open_o);
  // R4
  expire_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    expire_o |=> !expire_o);
  // R5
  restart_open_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (open_o && !expire_o));
  // R4
  counter_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= TERM_C);

endmodule

// File: rtl/parking_gate_ctrl.sv
module parking_gate_ctrl
  import pgate_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 500_000_000,
  parameter int unsigned CAPACITY    = 99,
  localparam int unsigned CNT_W      = $clog2(CAPACITY + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             card_ok_i,
  input  logic             exit_seen_i,
  output logic             barrier_open_o,
  output logic             hold_done_o,
  output logic [CNT_W-1:0] occupancy_o,
  output logic             lot_full_o
);

  pgate_evt_t lvl, evt;
  logic       admit;

  assign lvl.enter = card_ok_i;
  assign lvl.leave = exit_seen_i;

  pgate_edge #(.W(EVT_W)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (lvl),
    .rise_o (evt)
  );

  pgate_occupancy #(.CAPACITY(CAPACITY)) u_occ (
    .clk       (clk),
    .rst       (rst),
    .enter_req (evt.enter),
    .leave_req (evt.leave),
    .admit_o   (admit),
    .count_o   (occupancy_o),
    .full_o    (lot_full_o)
  );

  pgate_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .start_i  (admit),
    .open_o   (barrier_open_o),
    .expire_o (hold_done_o)
  );

  // R8
  refused_stays_chk: assert property (@(posedge clk) disable iff (rst)
    (lot_full_o && evt.enter && !barrier_open_o) |=> !barrier_open_o);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!barrier_open_o && !hold_done_o && occupancy_o == '0 && !lot_full_o));

endmodule

// File: tb/parking_gate_ctrl_test.sv
module parking_gate_ctrl_test;

  localparam int HOLD = 8;
  localparam int CAP  = 5;
  localparam int CW   = $clog2(CAP + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          card = 1'b0;
  logic          leave = 1'b0;
  logic          gate, done_p, full;
  logic [CW-1:0] occ;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  parking_gate_ctrl #(.HOLD_CYCLES(HOLD), .CAPACITY(CAP)) uut (
    .clk            (clk),
    .rst            (rst),
    .card_ok_i      (card),
    .exit_seen_i    (leave),
    .barrier_open_o (gate),
    .hold_done_o    (done_p),
    .occupancy_o    (occ),
    .lot_full_o     (full)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Drive inputs, let one rising edge pass, sample 1 ns after it
  task automatic cyc(bit c, bit e);
    card  = c;
    leave = e;
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog R1..all actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    // R1 reset state, with inputs toggling during reset
    cyc(1, 1); cyc(0, 0); cyc(1, 0);
    chk("R1 gate", gate, 0); chk("R1 pulse", done_p, 0);
    chk("R1 occ", occ, 0);   chk("R1 full", full, 0);
    rst = 1'b0;
    cyc(0, 0);

    // R2 admission, R3 held card, R4 exact window
    cyc(1, 0);
    chk("R2 gate", gate, 1); chk("R2 occ", occ, 1);
    for (int i = 1; i < HOLD; i++) begin
      cyc(i <= 3, 0);
      chk("R4 open window", gate, 1); chk("R4 no pulse", done_p, 0);
      chk("R3 held card once", occ, 1);
    end
    cyc(0, 0);
    chk("R4 closed", gate, 0); chk("R4 pulse", done_p, 1);
    cyc(0, 0);
    chk("R4 pulse one cycle", done_p, 0);

    // R5 restart mid-window
    cyc(1, 0); chk("R5 occ", occ, 2);
    cyc(0, 0); cyc(0, 0); cyc(0, 0);
    cyc(1, 0); chk("R5 occ again", occ, 3); chk("R5 gate", gate, 1);
    for (int i = 1; i < HOLD; i++) begin
      cyc(0, 0);
      chk("R5 restarted window", gate, 1);
    end
    cyc(0, 0);
    chk("R5 closes", gate, 0); chk("R5 pulse", done_p, 1);

    // R6 exit, R3 held exit
    cyc(0, 1); chk("R6 dec", occ, 2);
    cyc(0, 1); cyc(0, 1); chk("R3 held exit once", occ, 2);
    cyc(0, 0); cyc(0, 1); chk("R6 dec", occ, 1);
    cyc(0, 0); cyc(0, 1); chk("R6 dec", occ, 0);
    cyc(0, 0); cyc(0, 1); chk("R6 floor", occ, 0); chk("R9 empty", full, 0);
    cyc(0, 0);

    // R7 simultaneous entry and exit below capacity
    cyc(1, 0); cyc(0, 0); cyc(1, 0); cyc(0, 0);
    chk("R2 occ two", occ, 2);
    cyc(1, 1);
    chk("R7 occ", occ, 2); chk("R7 gate", gate, 1);
    cyc(0, 0);

    // R9 fill sweep
    for (int n = 3; n <= CAP; n++) begin
      cyc(1, 0);
      chk("R9 fill occ", occ, n); chk("R9 fill flag", full, n == CAP);
      cyc(0, 0);
    end
    repeat (HOLD + 1) cyc(0, 0);
    chk("R4 idle closed", gate, 0);

    // R8 refused at capacity
    cyc(1, 0);
    chk("R8 gate", gate, 0); chk("R8 occ", occ, CAP); chk("R10 flag", full, 1);
    cyc(0, 0);
    cyc(1, 1);
    chk("R8 exit at full", occ, CAP - 1); chk("R8 gate both", gate, 0);
    chk("R9 left full", full, 0);
    cyc(0, 0);
    cyc(1, 0);
    chk("R2 refill", occ, CAP); chk("R2 gate refill", gate, 1); chk("R9 refull", full, 1);

    // R9/R6 drain sweep
    for (int n = CAP - 1; n >= 0; n--) begin
      cyc(0, 0); cyc(0, 1);
      chk("R6 drain occ", occ, n); chk("R9 drain flag", full, 0);
    end

    // R1 reset with barrier open
    cyc(0, 0); cyc(1, 0);
    chk("R2 before reset", gate, 1);
    rst = 1'b1;
    cyc(0, 0);
    chk("R1 mid gate", gate, 0); chk("R1 mid occ", occ, 0);
    rst = 1'b0;
    cyc(0, 0);
    chk("R1 stays closed", gate, 0);

    finished = 1;
    summary();
    $finish;
  end

endmodule